// File: doc/BRIEF.md
# Indirect Pointer Load Unit

This block carries out one operation of a small 8-bit processor: read a byte from data memory through one of two 16-bit pointer registers and place it in the working register. Each operation names a pointer and picks one of two address forms. In the auto-modify form, the pointer is stepped up or down by one, either before or after the access. In the offset form, a small signed literal is added to the pointer to make the address, and the pointer itself stays as it was.

The memory read is combinational. The address is driven in the same cycle as the operation strobe, and the returned byte is registered on the next clock edge. The zero flag is the only status output, and only the moved byte decides its value. Pointer arithmetic never affects it. Each pointer can also be written directly through a load port, and a direct load wins over any auto-modify aimed at the same pointer in the same cycle.

Top module: `ptr_load_unit`

## Requirements
- R1: After reset, `w_out`, `z_out`, `ptr0_out` and `ptr1_out` are all zero.
- R2: With `op_offset_form`=0 and `op_mode`=2'b00 (step up first), `mem_addr` is pointer+1 in the strobe cycle, and the pointer becomes pointer+1 after the next edge.
- R3: With `op_offset_form`=0 and `op_mode`=2'b01 (step down first), `mem_addr` is pointer-1, and the pointer becomes pointer-1.
- R4: With `op_offset_form`=0 and `op_mode`=2'b10 (step up after) or 2'b11 (step down after), `mem_addr` is the unmodified pointer, and the pointer then becomes pointer+1 or pointer-1 respectively.
- R5: With `op_offset_form`=1, `mem_addr` is the pointer plus `op_offset`, which is read as 6-bit two's complement (-32..+31) and sign-extended. The pointer is unchanged. An offset of 0 addresses the pointer itself.
- R6: All pointer and address arithmetic wraps modulo 65536 (FFFFh+1 = 0000h, 0000h-1 = FFFFh).
- R7: On the clock edge that ends a strobe cycle, `w_out` takes `mem_rdata`, and `z_out` becomes 1 exactly when that byte is 00h and 0 otherwise.
- R8: Without a strobe, `w_out` and `z_out` hold their values. Pointer stepping and direct loads never change `z_out`.
- R9: The pointer that `op_sel` does not select holds its value unless it is loaded directly.
- R10: When `ptr_ld_en[i]` is high, pointer i takes its load data on the next edge. This has priority over an auto-modify to the same pointer in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | Pointer index (0 or 1) |
| op_offset_form | input | 1 | 1 = signed-offset form, 0 = auto-modify form |
| op_mode | input | 2 | Auto-modify mode: 00 step up first, 01 step down first, 10 step up after, 11 step down after |
| op_offset | input | 6 | Signed offset, two's complement |
| mem_addr | output | 16 | Effective data address |
| mem_rdata | input | 8 | Byte returned by data memory (combinational) |
| w_out | output | 8 | Working register |
| z_out | output | 1 | Zero flag |
| ptr_ld_en | input | 2 | Per-pointer direct load enable |
| ptr0_ld_data | input | 16 | Load value for pointer 0 |
| ptr1_ld_data | input | 16 | Load value for pointer 1 |
| ptr0_out | output | 16 | Pointer 0 value |
| ptr1_out | output | 16 | Pointer 1 value |

## Verification
`mem_addr` is due in the same cycle as the strobe, so the bench checks it one time unit after driving the inputs on the falling edge, before any clock edge has passed. `w_out`, `z_out` and both pointers are due one edge later. The bench samples them on the following falling edge, compares them against its own model, and then drives the next stimulus. No check waits more than one edge, so every result is compared in exactly the half cycle in which it first becomes valid.

// File: rtl/ptr_load_pkg.sv
package ptr_load_pkg;
    localparam int PTR_W_DEF  = 16;
    localparam int DATA_W_DEF = 8;
    localparam int OFF_W_DEF  = 6;

    typedef enum logic [1:0] {
        AM_PRE_INC  = 2'b00,
        AM_PRE_DEC  = 2'b01,
        AM_POST_INC = 2'b10,
        AM_POST_DEC = 2'b11
    } am_mode_e;
endpackage

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
    import ptr_load_pkg::*;
#(
    parameter int PTR_W = PTR_W_DEF,
    parameter int OFF_W = OFF_W_DEF
) (
    input  logic [PTR_W-1:0] ptr_cur,
    input  logic             offset_form,
    input  logic [1:0]       mode,
    input  logic [OFF_W-1:0] offset,
    output logic [PTR_W-1:0] eff_addr,
    output logic [PTR_W-1:0] ptr_next,
    output logic             ptr_write
);
    localparam int EXT_W = PTR_W - OFF_W;

    logic [PTR_W-1:0] off_ext;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    always_comb begin
        off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        // Arithmetic wraps naturally at PTR_W bits.
        ptr_up  = ptr_cur + PTR_W'(1);
        ptr_dn  = ptr_cur - PTR_W'(1);
        if (offset_form) begin
            eff_addr  = ptr_cur + off_ext;
            ptr_next  = ptr_cur;
            ptr_write = 1'b0;
        end else begin
            ptr_write = 1'b1;
            unique case (am_mode_e'(mode))
                AM_PRE_INC: begin
                    eff_addr = ptr_up;
                    ptr_next = ptr_up;
                end
                AM_PRE_DEC: begin
                    eff_addr = ptr_dn;
                    ptr_next = ptr_dn;
                end
                AM_POST_INC: begin
                    eff_addr = ptr_cur;
                    ptr_next = ptr_up;
                end
                default: begin
                    eff_addr = ptr_cur;
                    ptr_next = ptr_dn;
                end
            endcase
        end
    end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
    import ptr_load_pkg::*;
#(
    parameter int PTR_W = PTR_W_DEF,
    parameter int NPTR  = 2,
    localparam int SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [SEL_W-1:0]            upd_sel,
    input  logic [PTR_W-1:0]            upd_val,
    input  logic [NPTR-1:0]             ld_en,
    input  logic [NPTR-1:0][PTR_W-1:0]  ld_data,
    output logic [NPTR-1:0][PTR_W-1:0]  ptr_all
);
    typedef struct packed {
        logic [NPTR-1:0][PTR_W-1:0] ptr;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPTR; i++) begin
            if (ld_en[i]) begin
                st_d.ptr[i] = ld_data[i];
            end else if (upd_en && (upd_sel == SEL_W'(i))) begin
                st_d.ptr[i] = upd_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_all = st_q.ptr;

    genvar g;
    generate
        for (g = 0; g < NPTR; g++) begin : g_chk
            // R10: direct load wins over any update
            a_r10_load_priority: assert property (@(posedge clk) disable iff (!rst_n)
                ld_en[g] |=> ptr_all[g] == $past(ld_data[g]));
            // R9: untouched pointer keeps its value
            a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!ld_en[g] && !(upd_en && upd_sel == SEL_W'(g))) |=> $stable(ptr_all[g]));
        end
    endgenerate
endmodule

// File: rtl/acc_flags.sv
module acc_flags
    import ptr_load_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] w_q,
    output logic              z_q
);
    typedef struct packed {
        logic [DATA_W-1:0] w;
        logic              z;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.w = data_in;
            st_d.z = (data_in == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign w_q = st_q.w;
    assign z_q = st_q.z;

    // R8: no load, no change
    a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(w_q) && $stable(z_q));
endmodule

// File: rtl/ptr_load_unit.sv
module ptr_load_unit
    import ptr_load_pkg::*;
#(
    parameter int PTR_W  = PTR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int OFF_W  = OFF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_sel,
    input  logic              op_offset_form,
    input  logic [1:0]        op_mode,
    input  logic [OFF_W-1:0]  op_offset,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] w_out,
    output logic              z_out,
    input  logic [1:0]        ptr_ld_en,
    input  logic [PTR_W-1:0]  ptr0_ld_data,
    input  logic [PTR_W-1:0]  ptr1_ld_data,
    output logic [PTR_W-1:0]  ptr0_out,
    output logic [PTR_W-1:0]  ptr1_out
);
    localparam int NPTR = 2;

    logic [NPTR-1:0][PTR_W-1:0] ptr_all;
    logic [NPTR-1:0][PTR_W-1:0] ld_data;
    logic [PTR_W-1:0]           ptr_cur;
    logic [PTR_W-1:0]           ptr_next;
    logic                       ptr_write;

    assign ld_data  = {ptr1_ld_data, ptr0_ld_data};
    assign ptr_cur  = ptr_all[op_sel];
    assign ptr0_out = ptr_all[0];
    assign ptr1_out = ptr_all[1];

    ptr_addr_calc #(.PTR_W(PTR_W), .OFF_W(OFF_W)) u_calc (
        .ptr_cur     (ptr_cur),
        .offset_form (op_offset_form),
        .mode        (op_mode),
        .offset      (op_offset),
        .eff_addr    (mem_addr),
        .ptr_next    (ptr_next),
        .ptr_write   (ptr_write)
    );

    ptr_bank #(.PTR_W(PTR_W), .NPTR(NPTR)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (op_valid && ptr_write),
        .upd_sel (op_sel),
        .upd_val (ptr_next),
        .ld_en   (ptr_ld_en),
        .ld_data (ld_data),
        .ptr_all (ptr_all)
    );

    acc_flags #(.DATA_W(DATA_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op_valid),
        .data_in (mem_rdata),
        .w_q     (w_out),
        .z_q     (z_out)
    );

    // R7: W takes the byte read in the strobe cycle
    a_r7_w_load: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> w_out == $past(mem_rdata));
    // R7: Z mirrors zero-ness of the moved byte
    a_r7_z_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> z_out == ($past(mem_rdata) == '0));
    // R5: offset form leaves the selected pointer alone
    a_r5_offset_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_offset_form && !ptr_ld_en[op_sel])
            |=> ptr_all[$past(op_sel)] == $past(ptr_cur));
endmodule

// File: tb/ptr_load_unit_tb_top.sv
module ptr_load_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic        op_offset_form = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic [5:0]  op_offset = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  w_out;
    logic        z_out;
    logic [1:0]  ptr_ld_en = 2'b00;
    logic [15:0] ptr0_ld_data = '0;
    logic [15:0] ptr1_ld_data = '0;
    logic [15:0] ptr0_out;
    logic [15:0] ptr1_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_ptr [2];
    logic [7:0]  m_w;
    logic        m_z;

    always #2 clk = ~clk;

    ptr_load_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .op_offset_form(op_offset_form), .op_mode(op_mode), .op_offset(op_offset),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .w_out(w_out), .z_out(z_out),
        .ptr_ld_en(ptr_ld_en), .ptr0_ld_data(ptr0_ld_data), .ptr1_ld_data(ptr1_ld_data),
        .ptr0_out(ptr0_out), .ptr1_out(ptr1_out)
    );

    // Memory model: zero whenever the low nibble of the address is zero.
    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        if (a[3:0] == 4'h0) return 8'h00;
        return (a[7:0] ^ a[15:8] ^ 8'h5A) | 8'h01;
    endfunction

    always_comb mem_rdata = mem_fn(mem_addr);

    function automatic logic [15:0] exp_addr(input logic [15:0] p, input logic form,
                                             input logic [1:0] md, input logic [5:0] k);
        if (form) return p + {{10{k[5]}}, k};
        case (md)
            2'b00:   return p + 16'd1;
            2'b01:   return p - 16'd1;
            default: return p;
        endcase
    endfunction

    function automatic logic [15:0] exp_next(input logic [15:0] p, input logic form,
                                             input logic [1:0] md);
        if (form) return p;
        return md[0] ? p - 16'd1 : p + 16'd1;
    endfunction

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at falling edge, check address, cross one rising edge, check state.
    task automatic step(input string req, input logic v, input logic s, input logic form,
                        input logic [1:0] md, input logic [5:0] k,
                        input logic [1:0] ld, input logic [15:0] d0, input logic [15:0] d1);
        logic [15:0] ea;
        logic [7:0]  byte_v;
        op_valid = v; op_sel = s; op_offset_form = form; op_mode = md; op_offset = k;
        ptr_ld_en = ld; ptr0_ld_data = d0; ptr1_ld_data = d1;
        #1;
        ea = exp_addr(m_ptr[s], form, md, k);
        byte_v = mem_fn(ea);
        if (v) chk16({req, " addr"}, mem_addr, ea);
        if (v) begin
            m_w = byte_v;
            m_z = (byte_v == 8'h00);
            m_ptr[s] = exp_next(m_ptr[s], form, md);
        end
        if (ld[0]) m_ptr[0] = d0;
        if (ld[1]) m_ptr[1] = d1;
        @(negedge clk);
        chk16({req, " w"}, {8'h00, w_out}, {8'h00, m_w});
        chk16({req, " z R7/R8"}, {15'h0, z_out}, {15'h0, m_z});
        chk16({req, " ptr0 R9/R10"}, ptr0_out, m_ptr[0]);
        chk16({req, " ptr1 R9/R10"}, ptr1_out, m_ptr[1]);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        m_ptr[0] = '0; m_ptr[1] = '0; m_w = '0; m_z = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset values
        chk16("R1 w", {8'h00, w_out}, 16'h0);
        chk16("R1 z", {15'h0, z_out}, 16'h0);
        chk16("R1 ptr0", ptr0_out, 16'h0);
        chk16("R1 ptr1", ptr1_out, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: load both pointers
        step("R10 load", 1'b0, 1'b0, 1'b0, 2'b00, 6'd0, 2'b11, 16'hFFFF, 16'h0000);
        // R6 R2: step-up-first from FFFF wraps to 0000, byte 0 -> Z=1
        step("R2 R6 preinc wrap", 1'b1, 1'b0, 1'b0, 2'b00, 6'd0, 2'b00, 16'h0, 16'h0);
        // R8: load alone must not disturb Z
        step("R8 load keeps z", 1'b0, 1'b0, 1'b0, 2'b00, 6'd0, 2'b01, 16'h1234, 16'h0);
        // R8: idle cycle holds W and Z
        step("R8 idle", 1'b0, 1'b1, 1'b0, 2'b01, 6'd0, 2'b00, 16'h0, 16'h0);
        // R3 R6: step-down-first from 0000 wraps to FFFF
        step("R3 R6 predec wrap", 1'b1, 1'b1, 1'b0, 2'b01, 6'd0, 2'b00, 16'h0, 16'h0);
        // R4: step up after / step down after
        step("R4 postinc", 1'b1, 1'b0, 1'b0, 2'b10, 6'd0, 2'b00, 16'h0, 16'h0);
        step("R4 postdec", 1'b1, 1'b0, 1'b0, 2'b11, 6'd0, 2'b00, 16'h0, 16'h0);
        // R5: offset extremes and zero offset
        step("R5 load", 1'b0, 1'b0, 1'b0, 2'b00, 6'd0, 2'b11, 16'h0010, 16'hFFF0);
        step("R5 offset -32", 1'b1, 1'b0, 1'b1, 2'b00, 6'b100000, 2'b00, 16'h0, 16'h0);
        step("R5 R6 offset +31 wrap", 1'b1, 1'b1, 1'b1, 2'b00, 6'b011111, 2'b00, 16'h0, 16'h0);
        step("R5 offset 0", 1'b1, 1'b1, 1'b1, 2'b00, 6'd0, 2'b00, 16'h0, 16'h0);
        // R10: load beats auto-modify on same pointer; R9 other pointer holds
        step("R10 priority", 1'b1, 1'b0, 1'b0, 2'b00, 6'd0, 2'b01, 16'hABCD, 16'h0);
        step("R9 other loaded", 1'b1, 1'b0, 1'b0, 2'b10, 6'd0, 2'b10, 16'h0, 16'h5555);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom();
            step("rand R2-R10", r[0] | r[1], r[2], r[3], r[5:4], r[11:6],
                 (r[15:12] == 4'h0) ? r[17:16] : 2'b00, $urandom(), $urandom());
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule